// File: doc/BRIEF.md
# Channel Enable and Group Controller

This block owns the global enable vector of an event-channel fabric: one bit per channel, and a channel passes events only while its bit is 1. Software changes the vector in three ways. It can write the whole vector. It can use set and clear aliases, which touch only the bits written as 1. It can fire channel groups: a group is a stored inclusion mask with an "on" task and an "off" task, and each task switches every included channel at once. A group task fires either from a register write or from a pulse on an event channel that the group subscribes to. This lets hardware events open or close sets of channels without the CPU.

Every register access carries a secure flag, and a per-channel secure attribute vector comes from outside the block. Non-secure software cannot see or change anything that controls a secure channel. A group that includes any secure channel counts as secure as a whole. A non-secure group also ignores subscribed pulses that arrive on a secure channel. Event routing itself is outside this block.

Top module: `evtc_chan_ctrl`

## Requirements
- R1: After reset the enable vector, every group mask and every subscription register are zero, and every register reads back as zero.
- R2: A secure write to address 0x500 replaces the enable vector. The enable vector changes only on the clock edge after the write or triggering pulse, and a read of 0x500 returns the current vector in the same cycle.
- R3: A write to 0x504 sets each enable bit whose written bit is 1, and a write to 0x508 clears each such bit. Bits written as 0 keep their value, and a read of either address returns the enable vector.
- R4: For group n, writing 1 in bit 0 of 0x000+8n sets every enable bit included in the mask at 0x800+4n, and writing 1 in bit 0 of 0x004+8n clears them. A write with bit 0 equal to 0 has no effect.
- R5: When the on and off tasks fire in the same cycle, the channels of every firing off task end cleared.
- R6: When a direct write to 0x500, 0x504 or 0x508 and a group task touch the same channel in the same cycle, the group task result is the one kept.
- R7: The subscription register for group n's on task sits at 0x080+8n, and the one for its off task sits at 0x084+8n. Each holds a channel index in bits 7:0 and an enable bit in bit 31. A pulse on the selected channel fires the task only while the enable bit is 1 and the index is below the channel count.
- R8: A write to group n's mask is ignored while either of group n's subscription registers is enabled.
- R9: A non-secure access to 0x500, 0x504 or 0x508 leaves the enable bits of secure channels unchanged, and a non-secure read shows those bits as 0.
- R10: A group whose mask includes a secure channel is secure. Non-secure writes to its mask, subscription or task registers are ignored, and non-secure reads of them return 0. A non-secure mask write to a non-secure group stores 0 in the bits of secure channels.
- R11: A non-secure group ignores a subscribed pulse from a secure channel. A secure group accepts pulses from both secure and non-secure channels.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Register access in this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 12 | Byte address of the register |
| req_wdata | input | 32 | Write data |
| req_secure | input | 1 | Access is secure |
| rd_data | output | 32 | Read data, valid in the cycle of a read |
| chan_pulse | input | NUM_CH | One-cycle event pulses per channel |
| chan_secure | input | NUM_CH | Secure attribute per channel |
| chan_en | output | NUM_CH | Global channel enable vector |

## Verification
The enable vector is driven through a table of full writes, set and clear writes with mixed one and zero bits, and group on and off tasks over overlapping masks. This separates a whole-vector replace from a read-modify-write, and a task bit 0 of 1 from one of 0. Directed cases put a register write and a subscribed pulse in the same cycle, so that disable precedence and the order between a direct write and a group task show in the result. Further cases aim subscriptions at out-of-range indices and at secure channels, so a pulse that should be dropped can be told apart from one that fires. Secure and non-secure accesses to the same registers show per-bit filtering next to whole-group filtering.

// File: rtl/evtc_pkg.sv
package evtc_pkg;

    localparam int IDX_W       = 8;
    localparam int SUB_EN_BIT  = 31;
    localparam int DATA_W      = 32;

    localparam logic [11:0] A_TASK_BASE = 12'h000;
    localparam logic [11:0] A_SUB_BASE  = 12'h080;
    localparam logic [11:0] A_EN_ALL    = 12'h500;
    localparam logic [11:0] A_EN_SET    = 12'h504;
    localparam logic [11:0] A_EN_CLR    = 12'h508;
    localparam logic [11:0] A_MASK_BASE = 12'h800;

    typedef enum logic [3:0] {
        RK_NONE,
        RK_TASK_ON,
        RK_TASK_OFF,
        RK_SUB_ON,
        RK_SUB_OFF,
        RK_EN_ALL,
        RK_EN_SET,
        RK_EN_CLR,
        RK_MASK
    } reg_kind_e;

    typedef struct packed {
        logic             active;
        logic [IDX_W-1:0] src;
    } sub_cfg_t;

endpackage

// File: rtl/evtc_addr_decode.sv
module evtc_addr_decode
    import evtc_pkg::*;
#(
    parameter int NUM_GRP = 6,
    parameter int GRP_W   = 3
) (
    input  logic [11:0]      addr,
    output reg_kind_e        kind,
    output logic [GRP_W-1:0] grp
);

    localparam logic [11:0] TASK_END = A_TASK_BASE + 12'(8 * NUM_GRP);
    localparam logic [11:0] SUB_END  = A_SUB_BASE + 12'(8 * NUM_GRP);
    localparam logic [11:0] MASK_END = A_MASK_BASE + 12'(4 * NUM_GRP);

    logic [11:0] sub_off;
    logic [11:0] mask_off;

    assign sub_off  = addr - A_SUB_BASE;
    assign mask_off = addr - A_MASK_BASE;

    always_comb begin
        kind = RK_NONE;
        grp  = '0;
        if (addr[1:0] == 2'b00) begin
            if (addr < TASK_END) begin
                kind = addr[2] ? RK_TASK_OFF : RK_TASK_ON;
                grp  = GRP_W'(addr[11:3]);
            end else if (addr >= A_SUB_BASE && addr < SUB_END) begin
                kind = sub_off[2] ? RK_SUB_OFF : RK_SUB_ON;
                grp  = GRP_W'(sub_off[11:3]);
            end else if (addr >= A_MASK_BASE && addr < MASK_END) begin
                kind = RK_MASK;
                grp  = GRP_W'(mask_off[11:2]);
            end else if (addr == A_EN_ALL) begin
                kind = RK_EN_ALL;
            end else if (addr == A_EN_SET) begin
                kind = RK_EN_SET;
            end else if (addr == A_EN_CLR) begin
                kind = RK_EN_CLR;
            end
        end
    end

endmodule

// File: rtl/evtc_group_slot.sv
module evtc_group_slot
    import evtc_pkg::*;
#(
    parameter int NUM_CH = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_mask,
    input  logic              wr_sub_on,
    input  logic              wr_sub_off,
    input  logic              wr_task_on,
    input  logic              wr_task_off,
    input  logic              req_secure,
    input  logic [DATA_W-1:0] wdata,
    input  logic [NUM_CH-1:0] chan_pulse,
    input  logic [NUM_CH-1:0] chan_secure,
    output logic [NUM_CH-1:0] mask_o,
    output sub_cfg_t          sub_on_o,
    output sub_cfg_t          sub_off_o,
    output logic              is_secure_o,
    output logic              locked_o,
    output logic              fire_on_o,
    output logic              fire_off_o
);

    localparam int CH_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1;

    typedef struct packed {
        logic [NUM_CH-1:0] mask;
        sub_cfg_t          on;
        sub_cfg_t          off;
    } slot_t;

    slot_t st_q, st_d;
    logic  grp_secure;
    logic  allow;
    logic  hit_on, hit_off;

    function automatic logic sub_hit(input sub_cfg_t c,
                                     input logic [NUM_CH-1:0] pulse,
                                     input logic [NUM_CH-1:0] sec,
                                     input logic gsec);
        logic h;
        h = 1'b0;
        if (c.active && (int'(c.src) < NUM_CH)) begin
            h = pulse[c.src[CH_W-1:0]] && (gsec || !sec[c.src[CH_W-1:0]]);
        end
        return h;
    endfunction

    always_comb begin
        grp_secure = |(st_q.mask & chan_secure);
        allow      = req_secure || !grp_secure;
        hit_on     = sub_hit(st_q.on,  chan_pulse, chan_secure, grp_secure);
        hit_off    = sub_hit(st_q.off, chan_pulse, chan_secure, grp_secure);

        st_d = st_q;
        if (wr_mask && allow && !st_q.on.active && !st_q.off.active) begin
            st_d.mask = req_secure ? wdata[NUM_CH-1:0]
                                   : (wdata[NUM_CH-1:0] & ~chan_secure);
        end
        if (wr_sub_on && allow) begin
            st_d.on.active = wdata[SUB_EN_BIT];
            st_d.on.src    = wdata[IDX_W-1:0];
        end
        if (wr_sub_off && allow) begin
            st_d.off.active = wdata[SUB_EN_BIT];
            st_d.off.src    = wdata[IDX_W-1:0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign mask_o      = st_q.mask;
    assign sub_on_o    = st_q.on;
    assign sub_off_o   = st_q.off;
    assign is_secure_o = grp_secure;
    assign locked_o    = st_q.on.active || st_q.off.active;
    assign fire_on_o   = (wr_task_on && allow && wdata[0]) || hit_on;
    assign fire_off_o  = (wr_task_off && allow && wdata[0]) || hit_off;

endmodule

// File: rtl/evtc_chan_ctrl.sv
module evtc_chan_ctrl
    import evtc_pkg::*;
#(
    parameter int NUM_CH  = 32,
    parameter int NUM_GRP = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [11:0]       req_addr,
    input  logic [31:0]       req_wdata,
    input  logic              req_secure,
    output logic [31:0]       rd_data,
    input  logic [NUM_CH-1:0] chan_pulse,
    input  logic [NUM_CH-1:0] chan_secure,
    output logic [NUM_CH-1:0] chan_en
);

    localparam int GRP_W = (NUM_GRP > 1) ? $clog2(NUM_GRP) : 1;

    typedef struct packed {
        logic [NUM_CH-1:0] en;
    } ctrl_t;

    ctrl_t cur_q, cur_d;

    reg_kind_e                         kind;
    logic [GRP_W-1:0]                  grp;
    logic                              wr;
    logic [NUM_CH-1:0]                 vis;
    logic [NUM_CH-1:0]                 wbits;
    logic [NUM_GRP-1:0][NUM_CH-1:0]    mask_v;
    logic [NUM_GRP-1:0]                fire_on_v;
    logic [NUM_GRP-1:0]                fire_off_v;
    logic [NUM_GRP-1:0]                lock_v;
    logic [NUM_GRP-1:0]                sec_v;
    sub_cfg_t                          sub_on_v  [NUM_GRP];
    sub_cfg_t                          sub_off_v [NUM_GRP];
    logic [DATA_W-1:0]                 rd_val;

    evtc_addr_decode #(
        .NUM_GRP (NUM_GRP),
        .GRP_W   (GRP_W)
    ) u_dec (
        .addr (req_addr),
        .kind (kind),
        .grp  (grp)
    );

    assign wr    = req_valid && req_write;
    assign vis   = req_secure ? '1 : ~chan_secure;
    assign wbits = req_wdata[NUM_CH-1:0] & vis;

    for (genvar g = 0; g < NUM_GRP; g++) begin : g_slot
        logic sel;
        assign sel = (grp == GRP_W'(g));

        evtc_group_slot #(
            .NUM_CH (NUM_CH)
        ) u_slot (
            .clk         (clk),
            .rst_n       (rst_n),
            .wr_mask     (wr && sel && kind == RK_MASK),
            .wr_sub_on   (wr && sel && kind == RK_SUB_ON),
            .wr_sub_off  (wr && sel && kind == RK_SUB_OFF),
            .wr_task_on  (wr && sel && kind == RK_TASK_ON),
            .wr_task_off (wr && sel && kind == RK_TASK_OFF),
            .req_secure  (req_secure),
            .wdata       (req_wdata),
            .chan_pulse  (chan_pulse),
            .chan_secure (chan_secure),
            .mask_o      (mask_v[g]),
            .sub_on_o    (sub_on_v[g]),
            .sub_off_o   (sub_off_v[g]),
            .is_secure_o (sec_v[g]),
            .locked_o    (lock_v[g]),
            .fire_on_o   (fire_on_v[g]),
            .fire_off_o  (fire_off_v[g])
        );
    end

    // Next enable vector: direct write first, then group on tasks, then off tasks.
    always_comb begin
        cur_d = cur_q;
        if (wr) begin
            case (kind)
                RK_EN_ALL: cur_d.en = (cur_q.en & ~vis) | wbits;
                RK_EN_SET: cur_d.en = cur_q.en | wbits;
                RK_EN_CLR: cur_d.en = cur_q.en & ~wbits;
                default:   cur_d.en = cur_q.en;
            endcase
        end
        for (int g = 0; g < NUM_GRP; g++) begin
            if (fire_on_v[g]) cur_d.en = cur_d.en | mask_v[g];
        end
        for (int g = 0; g < NUM_GRP; g++) begin
            if (fire_off_v[g]) cur_d.en = cur_d.en & ~mask_v[g];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_q <= '0;
        end else begin
            cur_q <= cur_d;
        end
    end

    // Read path, filtered per bit and per group.
    always_comb begin
        rd_val = '0;
        case (kind)
            RK_EN_ALL, RK_EN_SET, RK_EN_CLR: rd_val = DATA_W'(cur_q.en & vis);
            RK_MASK, RK_SUB_ON, RK_SUB_OFF: begin
                for (int g = 0; g < NUM_GRP; g++) begin
                    if (grp == GRP_W'(g) && (req_secure || !sec_v[g])) begin
                        if (kind == RK_MASK)
                            rd_val = DATA_W'(mask_v[g]);
                        else if (kind == RK_SUB_ON)
                            rd_val = {sub_on_v[g].active, {(DATA_W-IDX_W-1){1'b0}}, sub_on_v[g].src};
                        else
                            rd_val = {sub_off_v[g].active, {(DATA_W-IDX_W-1){1'b0}}, sub_off_v[g].src};
                    end
                end
            end
            default: rd_val = '0;
        endcase
    end

    assign rd_data = (req_valid && !req_write) ? rd_val : '0;
    assign chan_en = cur_q.en;

endmodule

// File: rtl/evtc_chan_ctrl_chk.sv
module evtc_chan_ctrl_chk
    import evtc_pkg::*;
#(
    parameter int NUM_CH  = 32,
    parameter int NUM_GRP = 6
) (
    input logic                           clk,
    input logic                           rst_n,
    input logic                           req_valid,
    input logic                           req_write,
    input logic [11:0]                    req_addr,
    input logic                           req_secure,
    input logic [31:0]                    rd_data,
    input logic [NUM_CH-1:0]              chan_secure,
    input logic [NUM_CH-1:0]              chan_en,
    input logic [NUM_GRP-1:0][NUM_CH-1:0] mask_v,
    input logic [NUM_GRP-1:0]             fire_on_v,
    input logic [NUM_GRP-1:0]             fire_off_v,
    input logic [NUM_GRP-1:0]             lock_v
);

    logic wr, quiet;
    assign wr    = req_valid && req_write;
    assign quiet = (fire_on_v == '0) && (fire_off_v == '0);

    AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr && quiet) |=> $stable(chan_en)); // R2

    AST_SET_NEVER_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && req_addr == A_EN_SET && fire_off_v == '0) |=> ((chan_en & $past(chan_en)) == $past(chan_en))); // R3

    AST_CLR_NEVER_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && req_addr == A_EN_CLR && fire_on_v == '0) |=> ((chan_en & ~$past(chan_en)) == '0)); // R3

    AST_NS_KEEPS_SECURE: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && !req_secure && quiet) |=> (((chan_en ^ $past(chan_en)) & $past(chan_secure)) == '0)); // R9

    AST_NS_READ_HIDES: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_write && !req_secure && req_addr == A_EN_ALL)
            |-> ((rd_data[NUM_CH-1:0] & chan_secure) == '0)); // R9

    for (genvar g = 0; g < NUM_GRP; g++) begin : g_grp
        AST_LOCKED_MASK: assert property (@(posedge clk) disable iff (!rst_n)
            lock_v[g] |=> $stable(mask_v[g])); // R8

        AST_OFF_WINS: assert property (@(posedge clk) disable iff (!rst_n)
            fire_off_v[g] |=> ((chan_en & $past(mask_v[g])) == '0)); // R5

        AST_GROUP_LAST: assert property (@(posedge clk) disable iff (!rst_n)
            (fire_on_v[g] && fire_off_v == '0) |=> ((chan_en & $past(mask_v[g])) == $past(mask_v[g]))); // R6
    end

endmodule

bind evtc_chan_ctrl evtc_chan_ctrl_chk #(
    .NUM_CH  (NUM_CH),
    .NUM_GRP (NUM_GRP)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_valid   (req_valid),
    .req_write   (req_write),
    .req_addr    (req_addr),
    .req_secure  (req_secure),
    .rd_data     (rd_data),
    .chan_secure (chan_secure),
    .chan_en     (chan_en),
    .mask_v      (mask_v),
    .fire_on_v   (fire_on_v),
    .fire_off_v  (fire_off_v),
    .lock_v      (lock_v)
);

// File: tb/evtc_chan_ctrl_test.sv
module evtc_chan_ctrl_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic [11:0] req_addr = '0;
    logic [31:0] req_wdata = '0;
    logic        req_secure = 1'b0;
    logic [31:0] rd_data;
    logic [31:0] chan_pulse = '0;
    logic [31:0] chan_secure = '0;
    logic [31:0] chan_en;

    int n_run = 0;
    int n_fail = 0;

    always #5 clk = ~clk;

    evtc_chan_ctrl uut (
        .clk         (clk),
        .rst_n       (rst_n),
        .req_valid   (req_valid),
        .req_write   (req_write),
        .req_addr    (req_addr),
        .req_wdata   (req_wdata),
        .req_secure  (req_secure),
        .rd_data     (rd_data),
        .chan_pulse  (chan_pulse),
        .chan_secure (chan_secure),
        .chan_en     (chan_en)
    );

    typedef struct packed {
        logic [11:0] a;
        logic [31:0] d;
        logic [31:0] x;
    } vec_t;

    localparam int NV = 13;
    localparam vec_t TBL [NV] = '{
        '{12'h500, 32'h0000_00F0, 32'h0000_00F0},
        '{12'h504, 32'h0000_0F01, 32'h0000_0FF1},
        '{12'h508, 32'h0000_0030, 32'h0000_0FC1},
        '{12'h504, 32'h0000_0000, 32'h0000_0FC1},
        '{12'h508, 32'hFFFF_FFFF, 32'h0000_0000},
        '{12'h800, 32'h0000_FF00, 32'h0000_0000},
        '{12'h000, 32'h0000_0001, 32'h0000_FF00},
        '{12'h804, 32'h8000_0001, 32'h0000_FF00},
        '{12'h008, 32'h0000_0001, 32'h8000_FF01},
        '{12'h004, 32'h0000_0001, 32'h8000_0001},
        '{12'h00C, 32'h0000_0000, 32'h8000_0001},
        '{12'h00C, 32'h0000_0001, 32'h0000_0000},
        '{12'h500, 32'hA5A5_5A5A, 32'hA5A5_5A5A}
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic wr_pulse(input logic [11:0] a, input logic [31:0] d,
                            input logic sec, input logic [31:0] p);
        @(negedge clk);
        req_valid  = 1'b1;
        req_write  = 1'b1;
        req_addr   = a;
        req_wdata  = d;
        req_secure = sec;
        chan_pulse = p;
        @(negedge clk);
        req_valid  = 1'b0;
        req_write  = 1'b0;
        chan_pulse = '0;
    endtask

    task automatic bus_wr(input logic [11:0] a, input logic [31:0] d, input logic sec);
        wr_pulse(a, d, sec, '0);
    endtask

    task automatic pulse(input logic [31:0] p);
        @(negedge clk);
        chan_pulse = p;
        @(negedge clk);
        chan_pulse = '0;
    endtask

    task automatic bus_rd(input logic [11:0] a, input logic sec, output logic [31:0] v);
        @(negedge clk);
        req_valid  = 1'b1;
        req_write  = 1'b0;
        req_addr   = a;
        req_secure = sec;
        #1 v = rd_data;
        #1 req_valid = 1'b0;
    endtask

    task automatic finish_run();
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        logic [31:0] v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state
        @(negedge clk);
        chk("R1 enable vector", chan_en, 32'h0);
        bus_rd(12'h500, 1'b1, v); chk("R1 read 0x500", v, 32'h0);
        bus_rd(12'h800, 1'b1, v); chk("R1 read mask", v, 32'h0);
        bus_rd(12'h080, 1'b1, v); chk("R1 read subscription", v, 32'h0);

        // Table walk: direct writes (R2, R3) and group tasks (R4)
        for (int i = 0; i < NV; i++) begin
            bus_wr(TBL[i].a, TBL[i].d, 1'b1);
            if (TBL[i].a == 12'h500)
                chk("R2 table", chan_en, TBL[i].x);
            else if (TBL[i].a == 12'h504 || TBL[i].a == 12'h508)
                chk("R3 table", chan_en, TBL[i].x);
            else
                chk("R4 table", chan_en, TBL[i].x);
        end

        // R3: aliases read the enable vector; R4: mask readback
        bus_rd(12'h504, 1'b1, v); chk("R3 read set alias", v, 32'hA5A5_5A5A);
        bus_rd(12'h508, 1'b1, v); chk("R3 read clear alias", v, 32'hA5A5_5A5A);
        bus_rd(12'h800, 1'b1, v); chk("R4 mask readback", v, 32'h0000_FF00);

        // R2: change appears only after the edge
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b1; req_addr = 12'h500;
        req_wdata = 32'h0; req_secure = 1'b1;
        #1 chk("R2 before edge", chan_en, 32'hA5A5_5A5A);
        @(negedge clk);
        req_valid = 1'b0; req_write = 1'b0;
        chk("R2 after edge", chan_en, 32'h0);

        // R5: on task write and subscribed off pulse in the same cycle
        bus_wr(12'h808, 32'h0000_00F0, 1'b1);
        bus_wr(12'h094, 32'h8000_0005, 1'b1);
        bus_wr(12'h500, 32'h0000_00FF, 1'b1);
        wr_pulse(12'h010, 32'h1, 1'b1, 32'h0000_0020);
        chk("R5 off wins", chan_en, 32'h0000_000F);

        // R8: mask locked while subscribed
        bus_wr(12'h808, 32'h0000_FFFF, 1'b1);
        bus_rd(12'h808, 1'b1, v); chk("R8 locked mask", v, 32'h0000_00F0);
        bus_wr(12'h094, 32'h0, 1'b1);
        bus_wr(12'h808, 32'h0000_0F0F, 1'b1);
        bus_rd(12'h808, 1'b1, v); chk("R8 unlocked mask", v, 32'h0000_0F0F);

        // R7: subscription behaviour
        bus_wr(12'h500, 32'h0, 1'b1);
        bus_wr(12'h080, 32'h8000_001F, 1'b1);
        pulse(32'h8000_0000);
        chk("R7 subscribed pulse", chan_en, 32'h0000_FF00);
        bus_wr(12'h500, 32'h0, 1'b1);
        bus_wr(12'h080, 32'h8000_0028, 1'b1);
        pulse(32'hFFFF_FFFF);
        chk("R7 index out of range", chan_en, 32'h0);
        bus_wr(12'h080, 32'h0000_001F, 1'b1);
        pulse(32'h8000_0000);
        chk("R7 subscription disabled", chan_en, 32'h0);
        bus_rd(12'h080, 1'b1, v); chk("R7 subscription readback", v, 32'h0000_001F);

        // R6: direct clear and group on task in the same cycle
        bus_wr(12'h080, 32'h8000_001F, 1'b1);
        bus_wr(12'h500, 32'h0000_0100, 1'b1);
        wr_pulse(12'h508, 32'h0000_0100, 1'b1, 32'h8000_0000);
        chk("R6 group applied last", chan_en, 32'h0000_FF00);
        bus_wr(12'h080, 32'h0, 1'b1);

        // R9: per-bit filtering of non-secure accesses
        @(negedge clk);
        chan_secure = 32'h0000_000F;
        bus_wr(12'h500, 32'h0000_00FF, 1'b1);
        bus_wr(12'h508, 32'h0000_00FF, 1'b0);
        chk("R9 ns clear", chan_en, 32'h0000_000F);
        bus_wr(12'h504, 32'hFFFF_FFFF, 1'b0);
        chk("R9 ns set", chan_en, 32'hFFFF_FFFF);
        bus_wr(12'h500, 32'h0, 1'b0);
        chk("R9 ns full write", chan_en, 32'h0000_000F);
        bus_rd(12'h500, 1'b0, v); chk("R9 ns read", v, 32'h0);
        bus_rd(12'h500, 1'b1, v); chk("R9 secure read", v, 32'h0000_000F);

        // R10: secure groups
        bus_wr(12'h80C, 32'h0000_0003, 1'b1);
        bus_rd(12'h80C, 1'b0, v); chk("R10 ns mask read", v, 32'h0);
        bus_wr(12'h80C, 32'h0000_0030, 1'b0);
        bus_rd(12'h80C, 1'b1, v); chk("R10 ns mask write ignored", v, 32'h0000_0003);
        bus_wr(12'h01C, 32'h1, 1'b0);
        chk("R10 ns task ignored", chan_en, 32'h0000_000F);
        bus_wr(12'h01C, 32'h1, 1'b1);
        chk("R10 secure task", chan_en, 32'h0000_000C);
        bus_wr(12'h810, 32'h0000_00FF, 1'b0);
        bus_rd(12'h810, 1'b1, v); chk("R10 ns mask drops secure bits", v, 32'h0000_00F0);

        // R11: secure-channel pulses and group security
        bus_wr(12'h0A0, 32'h8000_0002, 1'b1);
        pulse(32'h0000_0004);
        chk("R11 ns group ignores secure pulse", chan_en, 32'h0000_000C);
        bus_wr(12'h098, 32'h8000_0002, 1'b1);
        bus_rd(12'h098, 1'b0, v); chk("R10 ns subscription read", v, 32'h0);
        pulse(32'h0000_0004);
        chk("R11 secure group accepts", chan_en, 32'h0000_000F);

        finish_run();
    end

endmodule